// File: doc/BRIEF.md
# Hardwired Instruction-Cycle Sequencer

This block is the control unit of a 16-bit single-accumulator computer. It runs a small step counter whose value is decoded into one-hot timing lines. It decodes the three opcode bits of the instruction word into eight class lines and keeps two state bits. The first is the addressing-mode bit, taken from the instruction word. The second is a pending-interrupt bit. From these it drives the bus source select, the load, clear and increment strobes of the address, program counter, instruction and temporary registers, and the memory read and write strobes. Together these carry out instruction fetch, decode, indirect address reads and the interrupt cycle.

Execution itself is left to the datapath. The sequencer raises a one-cycle start flag for register, I/O and memory-reference instructions. It then ends each instruction by returning the step counter to zero at the step that instruction's class or opcode requires. An interrupt-enable bit is held here and is set and cleared by pulses from the I/O execution logic. When it is set, a raised input or output device flag causes an interrupt cycle to take the place of the next fetch.

Top module: `cycle_sequencer`

## Requirements
- R1: A synchronous reset returns the step counter to step 0 (timing = 16'h0001) and clears the pending-interrupt bit and the interrupt-enable bit.
- R2: At step 0 with no pending interrupt, bus_sel = 3'b010 (program counter) and ar_ld = 1. No other strobe is active.
- R3: At step 1 with no pending interrupt, bus_sel = 3'b111 (memory), mem_rd = 1, ir_ld = 1 and pc_inr = 1. The step that follows is step 2.
- R4: opdec is one-hot with bit k set for k = ir[14:12]. The bit ir[15] is captured at step 2 and is shown on ind_bit from step 3 onward.
- R5: At step 3, opcode 7 with ind_bit = 0 raises go_reg, and opcode 7 with ind_bit = 1 raises go_io. Any other opcode with ind_bit = 1 gives ar_ld = 1, mem_rd = 1 and bus_sel = 3'b111. Any other opcode with ind_bit = 0 raises no strobe. mem_rd and mem_wr are never high together.
- R6: The step counter returns to step 0 after the last step of each instruction. For opcode 7 that is step 3. For opcodes 3 and 4 it is step 4. For opcodes 0, 1, 2 and 5 it is step 5. For opcode 6 it is step 6. The counter never passes 6.
- R7: For opcodes 0 to 6, go_mem is high at step 4.
- R8: The pending-interrupt bit is set at the end of any step other than 0, 1 or 2 when ien = 1 and fgi or fgo is 1. It is never set when ien = 0.
- R9: With the interrupt pending, step 0 gives ar_clr, tr_ld and bus_sel = 3'b010. Step 1 gives bus_sel = 3'b110 (temporary register), mem_wr and pc_clr. Step 2 gives pc_inr. After that cycle the counter is at step 0 and both the pending-interrupt bit and ien are 0.
- R10: While halt = 1, the step counter and the pending-interrupt bit hold their values and every strobe and start flag is 0.
- R11: An ien_on pulse sets ien from the next cycle on, and an ien_off pulse clears it. ien_off wins when both are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| halt | input | 1 | Freezes the sequence |
| ir | input | 16 | Instruction word held by the instruction register |
| fgi | input | 1 | Input device ready flag |
| fgo | input | 1 | Output device ready flag |
| ien_on | input | 1 | Interrupt enable set pulse |
| ien_off | input | 1 | Interrupt enable clear pulse |
| timing | output | 16 | One-hot decoded step |
| opdec | output | 8 | One-hot decoded opcode |
| ind_bit | output | 1 | Captured addressing-mode bit |
| int_req | output | 1 | Pending-interrupt bit |
| ien | output | 1 | Interrupt enable bit |
| bus_sel | output | 3 | Bus source select |
| ar_ld | output | 1 | Address register load |
| ar_clr | output | 1 | Address register clear |
| tr_ld | output | 1 | Temporary register load |
| ir_ld | output | 1 | Instruction register load |
| pc_inr | output | 1 | Program counter increment |
| pc_clr | output | 1 | Program counter clear |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| go_reg | output | 1 | Register-reference execution start |
| go_io | output | 1 | I/O execution start |
| go_mem | output | 1 | Memory-reference execution start |

## Verification
Strobes, the bus select, the timing lines and the start flags are combinational from the step counter and the state bits. They are due in the same cycle as the step that causes them. The step counter, ind_bit, int_req and ien change only at a clock edge, so their effect shows up one cycle after the condition. The bench drives inputs and samples outputs 5 ns after each rising edge. It checks each step in the cycle it belongs to. It checks flag updates in the cycle after the triggering step, for example int_req after step 3 and the cleared ien and int_req after interrupt step 2.

// File: rtl/cycle_sequencer.sv
`timescale 1ns/1ps
module cycle_sequencer #(
  parameter int WORD_W = 16,
  parameter int SC_W   = 4,
  parameter int OP_W   = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 halt,
  input  logic [WORD_W-1:0]    ir,
  input  logic                 fgi,
  input  logic                 fgo,
  input  logic                 ien_on,
  input  logic                 ien_off,
  output logic [(1<<SC_W)-1:0] timing,
  output logic [(1<<OP_W)-1:0] opdec,
  output logic                 ind_bit,
  output logic                 int_req,
  output logic                 ien,
  output logic [2:0]           bus_sel,
  output logic                 ar_ld,
  output logic                 ar_clr,
  output logic                 tr_ld,
  output logic                 ir_ld,
  output logic                 pc_inr,
  output logic                 pc_clr,
  output logic                 mem_rd,
  output logic                 mem_wr,
  output logic                 go_reg,
  output logic                 go_io,
  output logic                 go_mem
);
  localparam int T_N    = 1 << SC_W;
  localparam int D_N    = 1 << OP_W;
  localparam int OP_MSB = WORD_W - 2;

  logic [SC_W-1:0] sc;
  logic i_q, r_q, ien_q;

  assign timing = {{(T_N-1){1'b0}}, 1'b1} << sc;
  assign opdec  = {{(D_N-1){1'b0}}, 1'b1} << ir[OP_MSB -: OP_W];

  logic run, d7, t0, t1, t2, t3, t4, t5, t6;
  assign run = ~halt;
  assign d7  = opdec[D_N-1];
  assign t0  = timing[0];
  assign t1  = timing[1];
  assign t2  = timing[2];
  assign t3  = timing[3];
  assign t4  = timing[4];
  assign t5  = timing[5];
  assign t6  = timing[6];

  logic fetch0, fetch1, irq0, irq1, irq2, indir, exe_end, sc_clr, r_set;
  assign fetch0 = run & ~r_q & t0;
  assign fetch1 = run & ~r_q & t1;
  assign irq0   = run &  r_q & t0;
  assign irq1   = run &  r_q & t1;
  assign irq2   = run &  r_q & t2;
  assign indir  = run & ~d7 & i_q & t3;

  assign exe_end = run & ((d7 & t3) |
                   (~d7 & (((opdec[3] | opdec[4]) & t4) |
                           ((opdec[0] | opdec[1] | opdec[2] | opdec[5]) & t5) |
                           (opdec[6] & t6))));
  assign sc_clr  = exe_end | irq2;
  assign r_set   = run & ien_q & (fgi | fgo) & ~(t0 | t1 | t2);

  always_ff @(posedge clk) begin
    if (rst) begin
      sc    <= '0;
      i_q   <= 1'b0;
      r_q   <= 1'b0;
      ien_q <= 1'b0;
    end else begin
      if (sc_clr)   sc <= '0;
      else if (run) sc <= sc + SC_W'(1);
      if (fetch0 == 1'b0 && run && ~r_q && t2) i_q <= ir[WORD_W-1];
      if (irq2)       r_q <= 1'b0;
      else if (r_set) r_q <= 1'b1;
      if (irq2 | ien_off) ien_q <= 1'b0;
      else if (ien_on)    ien_q <= 1'b1;
    end
  end

  always_comb begin
    bus_sel = 3'b000;
    if (fetch0 | irq0) bus_sel = 3'b010;
    if (fetch1 | indir) bus_sel = 3'b111;
    if (irq1) bus_sel = 3'b110;
  end

  assign ind_bit = i_q;
  assign int_req = r_q;
  assign ien     = ien_q;
  assign ar_ld   = fetch0 | indir;
  assign ar_clr  = irq0;
  assign tr_ld   = irq0;
  assign ir_ld   = fetch1;
  assign pc_inr  = fetch1 | irq2;
  assign pc_clr  = irq1;
  assign mem_rd  = fetch1 | indir;
  assign mem_wr  = irq1;
  assign go_reg  = run & d7 & ~i_q & t3;
  assign go_io   = run & d7 &  i_q & t3;
  assign go_mem  = run & ~d7 & t4;

  // R6
  sc_range_chk: assert property (@(posedge clk) disable iff (rst) sc <= SC_W'(6));
  // R3
  fetch_next_chk: assert property (@(posedge clk) disable iff (rst) ir_ld |=> timing[2]);
  // R5
  rw_excl_chk: assert property (@(posedge clk) disable iff (rst) !(mem_rd && mem_wr));
  // R9
  irq_done_chk: assert property (@(posedge clk) disable iff (rst)
    (pc_inr && int_req) |=> (timing[0] && !int_req && !ien));
  // R10
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    halt |=> ($stable(timing) && $stable(int_req)));
  // R8
  req_set_chk: assert property (@(posedge clk) disable iff (rst)
    (!halt && ien && (fgi || fgo) && (timing[2:0] == 3'b000)) |=> int_req);
endmodule

// File: tb/cycle_sequencer_bench.sv
`timescale 1ns/1ps
module cycle_sequencer_bench;
  logic clk = 1'b0;
  logic rst = 1'b1, halt = 1'b0, fgi = 1'b0, fgo = 1'b0, ien_on = 1'b0, ien_off = 1'b0;
  logic [15:0] ir = 16'h7800;
  logic [15:0] timing;
  logic [7:0]  opdec;
  logic [2:0]  bus_sel;
  logic ind_bit, int_req, ien, ar_ld, ar_clr, tr_ld, ir_ld, pc_inr, pc_clr;
  logic mem_rd, mem_wr, go_reg, go_io, go_mem;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cycle_sequencer u_cycle_sequencer (
    .clk(clk), .rst(rst), .halt(halt), .ir(ir), .fgi(fgi), .fgo(fgo),
    .ien_on(ien_on), .ien_off(ien_off), .timing(timing), .opdec(opdec),
    .ind_bit(ind_bit), .int_req(int_req), .ien(ien), .bus_sel(bus_sel),
    .ar_ld(ar_ld), .ar_clr(ar_clr), .tr_ld(tr_ld), .ir_ld(ir_ld),
    .pc_inr(pc_inr), .pc_clr(pc_clr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .go_reg(go_reg), .go_io(go_io), .go_mem(go_mem));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  function automatic logic [10:0] strobes();
    return {ar_ld, ar_clr, tr_ld, ir_ld, pc_inr, pc_clr, mem_rd, mem_wr, go_reg, go_io, go_mem};
  endfunction

  // {instruction word, cycle count of the instruction}
  localparam logic [19:0] VEC [11] = '{
    {16'h7800, 4'd4}, {16'hF800, 4'd4}, {16'h0123, 4'd6}, {16'h8123, 4'd6},
    {16'h1000, 4'd6}, {16'h2000, 4'd6}, {16'h3456, 4'd5}, {16'hC010, 4'd5},
    {16'h4000, 4'd5}, {16'h5000, 4'd6}, {16'h6001, 4'd7}};

  initial begin
    tick(); tick();
    rst = 1'b0;
    check("R1 timing", timing, 16'h0001);
    check("R1 int_req", int_req, 0);
    check("R1 ien", ien, 0);

    for (int v = 0; v < 11; v++) begin
      logic [15:0] w;
      logic is7, ib;
      int len;
      w   = VEC[v][19:4];
      len = int'(VEC[v][3:0]);
      is7 = (w[14:12] == 3'd7);
      ib  = w[15];
      ir  = w;
      for (int c = 0; c < len; c++) begin
        check("R6 step", timing, 32'(1) << c);
        if (c == 0) begin
          check("R2 bus", bus_sel, 3'b010);
          check("R2 strobes", strobes(), 11'b10000000000);
        end
        if (c == 1) begin
          check("R3 bus", bus_sel, 3'b111);
          check("R3 strobes", strobes(), 11'b00011010000);
        end
        if (c == 2) check("R4 opdec", opdec, 8'd1 << w[14:12]);
        if (c == 3) begin
          check("R4 ind_bit", ind_bit, ib);
          check("R5 go_reg", go_reg, is7 & ~ib);
          check("R5 go_io", go_io, is7 & ib);
          check("R5 indirect read", {ar_ld, mem_rd}, {2{~is7 & ib}});
          check("R5 bus", bus_sel, (~is7 & ib) ? 3'b111 : 3'b000);
        end
        if (c == 4) check("R7 go_mem", go_mem, 1);
        tick();
      end
      check("R6 end", timing, 16'h0001);
    end

    // R10 halt at step 1
    ir = 16'h7800;
    tick();
    halt = 1'b1;
    #1;
    check("R10 strobes", strobes(), 0);
    tick(); tick(); tick();
    check("R10 hold", timing, 16'h0002);
    halt = 1'b0;
    #1;
    check("R10 resume", ir_ld, 1);
    tick(); tick(); tick();
    check("R10 finish", timing, 16'h0001);

    // R8 flag without enable
    fgo = 1'b1;
    for (int c = 0; c < 4; c++) tick();
    check("R8 no enable", int_req, 0);
    check("R8 step", timing, 16'h0001);
    fgo = 1'b0;

    // R11 set then clear, clear wins
    ien_on = 1'b1;
    tick();
    check("R11 set", ien, 1);
    ien_off = 1'b1;
    tick();
    check("R11 clear wins", ien, 0);
    ien_on = 1'b0; ien_off = 1'b0;
    tick(); tick();
    check("R11 step", timing, 16'h0001);

    // R8 / R9 interrupt cycle
    ien_on = 1'b1;
    tick();
    ien_on = 1'b0;
    fgi = 1'b1;
    tick();
    check("R8 not in T2", int_req, 0);
    tick();
    check("R8 not yet at T3", int_req, 0);
    tick();
    check("R8 set", int_req, 1);
    check("R9 RT0 step", timing, 16'h0001);
    check("R9 RT0 bus", bus_sel, 3'b010);
    check("R9 RT0 strobes", strobes(), 11'b01100000000);
    tick();
    check("R9 RT1 bus", bus_sel, 3'b110);
    check("R9 RT1 strobes", strobes(), 11'b00000101000);
    tick();
    check("R9 RT2 strobes", strobes(), 11'b00001000000);
    tick();
    check("R9 step", timing, 16'h0001);
    check("R9 int_req", int_req, 0);
    check("R9 ien", ien, 0);
    check("R9 fetch resumes", bus_sel, 3'b010);
    fgi = 1'b0;

    // R1 reset mid instruction
    tick(); tick();
    ien_on = 1'b1;
    tick();
    ien_on = 1'b0;
    rst = 1'b1;
    tick();
    rst = 1'b0;
    check("R1 reset step", timing, 16'h0001);
    check("R1 reset ien", ien, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule